// File: doc/BRIEF.md
# Hot-Swap Slot Control and Power-Good Register

This block is the per-slot control and status register of a hot-swap power controller. A register bus, already decoded into a command code plus write and read strobes, reaches it. Three writable bits set the slot's behaviour: one switches the main supply outputs, one switches the auxiliary output, and one masks an external force-on override. Two read-only bits report whether the main and the auxiliary outputs are above their undervoltage limits. These flags come from comparator inputs that are brought into the clock domain by a synchronizer.

From the two flags the block drives an active-low, open-drain power-good pin, shown here as an output enable. When the enable is 1 the pin is pulled low, which means power is good. When it is 0 the pin is released, which means power is not good. A low level on the force-on input releases the pin unconditionally unless the mask bit is set. The flags read back over the bus always show the true supply state, whatever the override does.

A read returns its data on a one-cycle response pulse. This response has no ready signal and cannot be back-pressured. The requester must accept the data in the cycle after the read strobe.

Top module: `slot_pg_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, main_en, aux_en, pg_oe and rsp_valid are 0. The stored control bits are 0.
- R2: A write strobe with command code 0x03 loads wdata bit 1 into main_en and wdata bit 0 into aux_en, both visible in the next cycle. It loads wdata bit 2 into the force-mask bit. A bit value of 1 means on.
- R3: A write strobe with any command code other than 0x03 leaves main_en, aux_en and the force-mask bit unchanged.
- R4: A read strobe with command code 0x03 produces exactly one rsp_valid pulse in the next cycle. rsp_data bit 7 holds the auxiliary power-good flag, bit 6 the main power-good flag, bit 2 the force-mask bit, bit 1 the main enable and bit 0 the auxiliary enable.
- R5: Response bits 5 to 3 are always 0, even after a write of all ones.
- R6: Each raw power-good input passes through a two-flop synchronizer. A change on the raw inputs reaches pg_oe on the third rising edge and not earlier.
- R7: pg_oe is 1 only when both synchronized flags are 1 and the override is not active. The override is active when force_on_n is 0 and the force-mask bit is 0. A force-mask bit of 1 makes force_on_n have no effect.
- R8: The override never changes response bits 7 and 6.
- R9: When read and write strobes for 0x03 arrive in the same cycle, the response carries the contents held before the write, and the write still takes effect.
- R10: A read strobe with a command code other than 0x03 produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cmd | input | 8 | Decoded command code of the current access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read strobe |
| rsp_data | output | 8 | Read response data |
| main_pg_raw | input | 1 | Asynchronous main power-good comparator result |
| aux_pg_raw | input | 1 | Asynchronous auxiliary power-good comparator result |
| force_on_n | input | 1 | Asynchronous active-low force-on override |
| main_en | output | 1 | Main outputs enable |
| aux_en | output | 1 | Auxiliary output enable |
| pg_oe | output | 1 | Power-good pin pull-down enable (1 = pulled low = good) |

## Verification
A read and a write of the slot register can land in the same cycle. The bench provokes this by raising both strobes together with new write data while the register holds a known value. The scoreboard expects the response to carry the old control bits. A following read must show the new bits, and the enable pins must change in the cycle after the strobe. A second collision is between the force-on override and a read of the flags. With the override holding the pin released, the response must still report both flags as good.

// File: rtl/slot_pg_pkg.sv
package slot_pg_pkg;
  localparam int REG_W       = 8;
  localparam int BIT_AUX_PG  = 7;
  localparam int BIT_MAIN_PG = 6;
  localparam int BIT_FMASK   = 2;
  localparam int BIT_MAIN_EN = 1;
  localparam int BIT_AUX_EN  = 0;

  typedef struct packed {
    logic force_mask;
    logic main_on;
    logic aux_on;
  } slot_ctrl_t;

  function automatic slot_ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
    slot_ctrl_t c;
    c.force_mask = w[BIT_FMASK];
    c.main_on    = w[BIT_MAIN_EN];
    c.aux_on     = w[BIT_AUX_EN];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input slot_ctrl_t c,
                                                   input logic aux_pg,
                                                   input logic main_pg);
    logic [REG_W-1:0] r;
    r              = '0;
    r[BIT_AUX_PG]  = aux_pg;
    r[BIT_MAIN_PG] = main_pg;
    r[BIT_FMASK]   = c.force_mask;
    r[BIT_MAIN_EN] = c.main_on;
    r[BIT_AUX_EN]  = c.aux_on;
    return r;
  endfunction
endpackage

// File: rtl/slot_pg_sync.sv
module slot_pg_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/slot_pg_regfile.sv
module slot_pg_regfile
  import slot_pg_pkg::*;
#(
  parameter logic [REG_W-1:0] CMD_CODE = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] bus_cmd,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             aux_pg_s,
  input  logic             main_pg_s,
  output slot_ctrl_t       ctrl,
  output logic             rsp_valid,
  output logic [REG_W-1:0] rsp_data
);
  logic hit;
  logic wr_hit;
  logic rd_hit;

  assign hit    = (bus_cmd == CMD_CODE);
  assign wr_hit = bus_wr && hit;
  assign rd_hit = bus_rd && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_hit) begin
      ctrl <= unpack_ctrl(bus_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_hit;
      if (rd_hit) rsp_data <= pack_status(ctrl, aux_pg_s, main_pg_s);
    end
  end
endmodule

// File: rtl/slot_pg_pin.sv
module slot_pg_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic aux_pg_s,
  input  logic main_pg_s,
  input  logic force_n_s,
  input  logic force_mask,
  output logic pg_oe
);
  logic override;
  logic good_next;

  assign override  = !force_n_s && !force_mask;
  assign good_next = aux_pg_s && main_pg_s && !override;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_oe <= 1'b0;
    else        pg_oe <= good_next;
  end
endmodule

// File: rtl/slot_pg_ctrl.sv
module slot_pg_ctrl
  import slot_pg_pkg::*;
#(
  parameter logic [7:0] CMD_CODE    = 8'h03,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_cmd,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  input  logic       main_pg_raw,
  input  logic       aux_pg_raw,
  input  logic       force_on_n,
  output logic       main_en,
  output logic       aux_en,
  output logic       pg_oe
);
  logic [1:0] pg_s;
  logic       force_n_s;
  slot_ctrl_t ctrl;

  slot_pg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_pg_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({aux_pg_raw, main_pg_raw}),
    .q (pg_s)
  );

  slot_pg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_force_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (force_on_n),
    .q (force_n_s)
  );

  slot_pg_regfile #(.CMD_CODE(CMD_CODE)) u_regs (
    .clk (clk),
    .rst_n (rst_n),
    .bus_cmd (bus_cmd),
    .bus_wr (bus_wr),
    .bus_rd (bus_rd),
    .bus_wdata (bus_wdata),
    .aux_pg_s (pg_s[1]),
    .main_pg_s (pg_s[0]),
    .ctrl (ctrl),
    .rsp_valid (rsp_valid),
    .rsp_data (rsp_data)
  );

  slot_pg_pin u_pin (
    .clk (clk),
    .rst_n (rst_n),
    .aux_pg_s (pg_s[1]),
    .main_pg_s (pg_s[0]),
    .force_n_s (force_n_s),
    .force_mask (ctrl.force_mask),
    .pg_oe (pg_oe)
  );

  assign main_en = ctrl.main_on;
  assign aux_en  = ctrl.aux_on;
endmodule

// File: rtl/slot_pg_ctrl_chk.sv
module slot_pg_ctrl_chk #(
  parameter logic [7:0] CMD_CODE    = 8'h03,
  parameter int         SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_cmd,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic       main_pg_raw,
  input logic       aux_pg_raw,
  input logic       main_en,
  input logic       aux_en,
  input logic       pg_oe
);
  localparam int LAT = SYNC_STAGES + 1;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rsp_valid && !main_en && !aux_en && !pg_oe)); // R1

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_cmd == CMD_CODE) |=>
      (main_en == $past(bus_wdata[1]) && aux_en == $past(bus_wdata[0]))); // R2

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_cmd == CMD_CODE) |=> $stable({main_en, aux_en})); // R3

  AST_RSP_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_rd && bus_cmd == CMD_CODE)); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[5:3] == 3'b000)); // R5

  AST_PG_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    pg_oe |-> ($past(main_pg_raw, LAT) && $past(aux_pg_raw, LAT))); // R7
endmodule

bind slot_pg_ctrl slot_pg_ctrl_chk #(.CMD_CODE(CMD_CODE), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .bus_cmd (bus_cmd),
  .bus_wr (bus_wr),
  .bus_rd (bus_rd),
  .bus_wdata (bus_wdata),
  .rsp_valid (rsp_valid),
  .rsp_data (rsp_data),
  .main_pg_raw (main_pg_raw),
  .aux_pg_raw (aux_pg_raw),
  .main_en (main_en),
  .aux_en (aux_en),
  .pg_oe (pg_oe)
);

// File: tb/slot_pg_ctrl_tb.sv
module slot_pg_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_cmd = 8'h00;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       main_pg_raw = 1'b0;
  logic       aux_pg_raw = 1'b0;
  logic       force_on_n = 1'b1;
  logic       main_en;
  logic       aux_en;
  logic       pg_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] exp_ctrl = 3'b000;

  always #2 clk = ~clk;

  slot_pg_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .bus_cmd (bus_cmd), .bus_wr (bus_wr),
    .bus_rd (bus_rd), .bus_wdata (bus_wdata), .rsp_valid (rsp_valid),
    .rsp_data (rsp_data), .main_pg_raw (main_pg_raw), .aux_pg_raw (aux_pg_raw),
    .force_on_n (force_on_n), .main_en (main_en), .aux_en (aux_en), .pg_oe (pg_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Driver: one bus cycle; expected responses go to the scoreboard queue.
  task automatic bus_op(input bit wr, input bit rd, input logic [7:0] cmd,
                        input logic [7:0] wd, input string tag);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_cmd = cmd; bus_wdata = wd;
    if (rd && cmd == 8'h03) begin
      exp_q.push_back({aux_pg_raw, main_pg_raw, 3'b000, exp_ctrl});
      tag_q.push_back(tag);
    end
    if (wr && cmd == 8'h03) exp_ctrl = wd[2:0];
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_cmd = 8'h00; bus_wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected response", rsp_data, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #40000;
    check(1'b0, "watchdog expired", 8'h00, 8'h00);
    finish_run();
  end

  initial begin
    idle(3);
    check({main_en, aux_en, pg_oe, rsp_valid} == 4'b0, "R1 in reset",
          {4'b0, main_en, aux_en, pg_oe, rsp_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check({main_en, aux_en, pg_oe, rsp_valid} == 4'b0, "R1 after reset",
          {4'b0, main_en, aux_en, pg_oe, rsp_valid}, 8'h00);
    bus_op(0, 1, 8'h03, 8'h00, "R1 R4 reset readback");
    idle(1);

    bus_op(1, 0, 8'h03, 8'hFF, "R2 write ff");
    check({main_en, aux_en} == 2'b11, "R2 both on", {6'b0, main_en, aux_en}, 8'h03);
    bus_op(0, 1, 8'h03, 8'h00, "R5 reserved read zero");
    idle(1);

    bus_op(1, 0, 8'h04, 8'h00, "R3 other cmd");
    check({main_en, aux_en} == 2'b11, "R3 other cmd ignored", {6'b0, main_en, aux_en}, 8'h03);
    bus_op(0, 1, 8'h03, 8'h00, "R3 readback after ignored write");
    idle(1);

    bus_op(1, 0, 8'h03, 8'h02, "R2 main only");
    check({main_en, aux_en} == 2'b10, "R2 main only", {6'b0, main_en, aux_en}, 8'h02);
    bus_op(1, 0, 8'h03, 8'h01, "R2 aux only");
    check({main_en, aux_en} == 2'b01, "R2 aux only", {6'b0, main_en, aux_en}, 8'h01);

    bus_op(0, 1, 8'h05, 8'h00, "R10 other cmd read");
    idle(3);
    check(exp_q.size() == 0, "R10 no response", 8'(exp_q.size()), 8'h00);

    main_pg_raw = 1'b1; aux_pg_raw = 1'b0;
    idle(4);
    check(pg_oe == 1'b0, "R7 main only good", {7'b0, pg_oe}, 8'h00);
    aux_pg_raw = 1'b1;
    idle(4);
    check(pg_oe == 1'b1, "R7 both good", {7'b0, pg_oe}, 8'h01);
    bus_op(0, 1, 8'h03, 8'h00, "R4 flags read");
    idle(1);

    @(negedge clk);
    aux_pg_raw = 1'b0;
    idle(2);
    check(pg_oe == 1'b1, "R6 still good after two edges", {7'b0, pg_oe}, 8'h01);
    idle(1);
    check(pg_oe == 1'b0, "R6 drops on third edge", {7'b0, pg_oe}, 8'h00);
    aux_pg_raw = 1'b1;
    idle(4);

    bus_op(1, 0, 8'h03, 8'h03, "R7 mask clear");
    force_on_n = 1'b0;
    idle(4);
    check(pg_oe == 1'b0, "R7 override releases pin", {7'b0, pg_oe}, 8'h00);
    bus_op(0, 1, 8'h03, 8'h00, "R8 flags under override");
    idle(1);
    bus_op(1, 0, 8'h03, 8'h07, "R7 mask set");
    idle(2);
    check(pg_oe == 1'b1, "R7 mask blocks override", {7'b0, pg_oe}, 8'h01);
    force_on_n = 1'b1;
    idle(3);

    bus_op(1, 1, 8'h03, 8'h00, "R9 collision returns old");
    check({main_en, aux_en} == 2'b00, "R9 write applied", {6'b0, main_en, aux_en}, 8'h00);
    bus_op(0, 1, 8'h03, 8'h00, "R9 readback new");
    idle(3);
    check(exp_q.size() == 0, "R4 all responses seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule